// File: doc/BRIEF.md
# Word-Wide 8b/10b Line Encoder

This block sits between system logic that produces two-byte words and a serializer that takes one 10-bit code per clock. On each rising edge it samples a 16-bit word, two per-byte control flags and an active-low write strobe. A strobed word waits in a holding stage until the next word slot starts. A slot lasts two clocks. The word then leaves as two consecutive codes, upper byte first. Each byte becomes a data character or a control character, depending on its flag. The running disparity is tracked across every code, and the chosen sub-blocks are complemented whenever the disparity is positive.

When no word is waiting, the slot carries an idle pair: the comma character K28.5 followed by D16.2. A byte that is flagged as control but is not a legal control character goes out as the data encoding of the same value. In the same clock, a one-cycle error output is raised. The number of bytes per word is the parameter `LANES`, which is 2 by default. The clock of the block is the code clock, so words are accepted at half of that rate.

Top module: `wordpair_8b10b_tx`

## Requirements
- R1: An asynchronous active-low reset clears `code_out` to 0, clears `bad_ctl` and sets the running disparity to negative. The first code driven after reset is released is K28.5 in its negative-disparity form, 10'h17C.
- R2: Word and flags are registered on every rising edge. A word is taken only from an edge at which `wr_n` is low. While `wr_n` is high, changes on `word_in` and `ctl_in` leave the idle output untouched.
- R3: A taken word is sent as two codes in adjacent clocks. First comes bits 15:8 (flag bit 1), then bits 7:0 (flag bit 0). The first code appears after the second or third rising edge following the strobe edge, whichever of the two begins a word slot. Slots start at the first edge after reset and recur every `LANES` clocks.
- R4: A slot with no word waiting emits K28.5 (byte 8'hBC, control) and then D16.2 (byte 8'h50, data).
- R5: A byte that is flagged as control but lies outside the legal set of R9 is sent as the data encoding of its value. `bad_ctl` is high for exactly the clock in which that code is on `code_out`.
- R6: Every code holds 4, 5 or 6 ones. The running disparity summed over all codes stays at -1 or +1. The serial stream, taken bit 0 first, never has more than five equal bits in a row.
- R7: The code is laid out with sub-block bits a,b,c,d,e,i on output bits 0..5 and f,g,h,j on output bits 6..9.
- R8: Strobes spaced `LANES` clocks apart are sent back to back with no idle between them. A newer strobe that arrives before the waiting word has started replaces that word.
- R9: The legal control bytes are those whose low five bits equal 28 (K28.0 to K28.7), plus 8'hF7, 8'hFB, 8'hFD and 8'hFE (K23.7, K27.7, K29.7, K30.7). These are sent as control characters with `bad_ctl` low.
- R10: Byte bits 4:0 select the 6-bit sub-block and bits 7:5 select the 4-bit sub-block, following the standard 8b/10b tables. For D.x.7, the alternate form is used when x is 17, 18 or 20 at negative disparity, or when x is 11, 13 or 14 at positive disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code clock, one 10-bit code per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low, one clock wide |
| word_in | input | LANES*8 | Word to send, most significant byte sent first |
| ctl_in | input | LANES | Per-byte control flag; bit n qualifies byte n |
| code_out | output | 10 | Encoded code toward the serializer |
| bad_ctl | output | 1 | High in the clock whose code came from an illegal control request |

## Verification
The bench builds the block with the default `LANES` = 2, so each word slot is two clocks long. This makes both slot phases reachable just by varying the strobe spacing. Strobes two clocks apart keep the line full with no idle pair between words. Strobes on adjacent clocks can land inside one slot window and exercise the replacement rule. Because the codes alternate between disparity states, random data streams drive every table entry through both its positive and its negative form, including the alternate D.x.7 cases.

// File: rtl/wp_tx_pkg.sv
package wp_tx_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned CODE_W     = 10;
    localparam logic [7:0]  COMMA_BYTE = 8'hBC;   // K28.5
    localparam logic [7:0]  FILL_BYTE  = 8'h50;   // D16.2

    typedef struct packed {
        logic              ctl;
        logic [BYTE_W-1:0] val;
    } lane_t;

    // 6-bit sub-block, negative-disparity form, written a..i from MSB down
    function automatic logic [5:0] six_rdneg(input logic [4:0] x);
        logic [5:0] r;
        case (x)
            5'd0:  r = 6'b100111;
            5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;
            5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;
            5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;
            5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;
            5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;
            5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;
            5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;
            5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;
            5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;
            5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;
            5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;
            5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;
            5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;
            5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;
            5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;
            default: r = 6'b101011;
        endcase
        return r;
    endfunction

    // 4-bit data sub-block, negative-disparity form, f..j from MSB down
    function automatic logic [3:0] four_data_rdneg(input logic [2:0] y, input logic alt);
        logic [3:0] r;
        case (y)
            3'd0: r = 4'b1011;
            3'd1: r = 4'b1001;
            3'd2: r = 4'b0101;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = 4'b1010;
            3'd6: r = 4'b0110;
            default: r = alt ? 4'b0111 : 4'b1110;
        endcase
        return r;
    endfunction

    // 4-bit control sub-block, negative-disparity form
    function automatic logic [3:0] four_ctl_rdneg(input logic [2:0] y);
        logic [3:0] r;
        case (y)
            3'd0: r = 4'b1011;
            3'd1: r = 4'b0110;
            3'd2: r = 4'b1010;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = 4'b0101;
            3'd6: r = 4'b1001;
            default: r = 4'b0111;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wp_byte_sched.sv
module wp_byte_sched
    import wp_tx_pkg::*;
#(
    parameter int unsigned LANES = 2
)
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_n,
    input  logic [LANES*BYTE_W-1:0] word_i,
    input  logic [LANES-1:0]        ctl_i,
    output lane_t                   cur_o
);

    localparam int unsigned WORD_W = LANES * BYTE_W;
    localparam int unsigned SLOT_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANES - 1);

    typedef struct packed {
        logic                     strb;
        logic [WORD_W-1:0]        word;
        logic [LANES-1:0]         ctl;
        logic                     pend_v;
        logic [WORD_W-1:0]        pend_word;
        logic [LANES-1:0]         pend_ctl;
        logic [SLOT_W-1:0]        slot;
        lane_t [LANES-1:0]        hold;
    } sched_t;

    sched_t            st_d, st_q;
    lane_t [LANES-1:0] src;

    // lane source: waiting word, or idle pattern alternating comma / filler
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_src
            localparam bit IS_COMMA = (((LANES - 1 - j) % 2) == 0);
            assign src[j] = st_q.pend_v
                          ? {st_q.pend_ctl[j], st_q.pend_word[j*BYTE_W +: BYTE_W]}
                          : (IS_COMMA ? {1'b1, COMMA_BYTE} : {1'b0, FILL_BYTE});
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.strb = ~wr_n;
        st_d.word = word_i;
        st_d.ctl  = ctl_i;
        if (st_q.strb) begin
            st_d.pend_v    = 1'b1;
            st_d.pend_word = st_q.word;
            st_d.pend_ctl  = st_q.ctl;
        end else if (st_q.slot == '0) begin
            st_d.pend_v = 1'b0;
        end
        if (st_q.slot == '0) begin
            st_d.hold = src;
        end
        st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o = (st_q.slot == '0) ? src[LANES-1] : st_q.hold[LAST_SLOT - st_q.slot];

    // R2
    strobe_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strb |=> st_q.pend_v);

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_v && (st_q.slot != '0)) |=> st_q.pend_v);

endmodule

// File: rtl/wp_char_enc.sv
module wp_char_enc
    import wp_tx_pkg::*;
(
    input  lane_t              sym_i,
    input  logic               rd_i,
    output logic [CODE_W-1:0]  code_o,
    output logic               rd_o,
    output logic               bad_o
);

    logic [4:0] lo5;
    logic [2:0] hi3;
    logic       legal, as_k;
    logic [5:0] b6, s6;
    logic [3:0] b4, s4;
    logic       inv6, inv4, rd_mid, alt7;

    always_comb begin
        lo5    = sym_i.val[4:0];
        hi3    = sym_i.val[7:5];
        legal  = (lo5 == 5'd28) || (sym_i.val inside {8'hF7, 8'hFB, 8'hFD, 8'hFE});
        as_k   = sym_i.ctl && legal;
        bad_o  = sym_i.ctl && !legal;

        b6     = (as_k && (lo5 == 5'd28)) ? 6'b001111 : six_rdneg(lo5);
        inv6   = ($countones(b6) != 3) || (lo5 == 5'd7);
        s6     = (rd_i && inv6) ? ~b6 : b6;
        rd_mid = rd_i ^ ($countones(b6) != 3);

        alt7   = rd_mid ? (lo5 inside {5'd11, 5'd13, 5'd14})
                        : (lo5 inside {5'd17, 5'd18, 5'd20});
        b4     = as_k ? four_ctl_rdneg(hi3) : four_data_rdneg(hi3, alt7);
        inv4   = as_k || ($countones(b4) != 2) || (hi3 == 3'd3);
        s4     = (rd_mid && inv4) ? ~b4 : b4;
        rd_o   = rd_mid ^ ($countones(b4) != 2);

        // a on bit 0 ... i on bit 5, f on bit 6 ... j on bit 9
        code_o = {s4[0], s4[1], s4[2], s4[3], s6[0], s6[1], s6[2], s6[3], s6[4], s6[5]};
    end

endmodule

// File: rtl/wordpair_8b10b_tx.sv
module wordpair_8b10b_tx
    import wp_tx_pkg::*;
#(
    parameter int unsigned LANES = 2
)
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_n,
    input  logic [LANES*BYTE_W-1:0] word_in,
    input  logic [LANES-1:0]        ctl_in,
    output logic [CODE_W-1:0]       code_out,
    output logic                    bad_ctl
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              rd;
        logic              bad;
    } line_t;

    line_t             ln_d, ln_q;
    lane_t             cur;
    logic [CODE_W-1:0] enc_code;
    logic              enc_rd;
    logic              enc_bad;

    wp_byte_sched #(.LANES(LANES)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .word_i (word_in),
        .ctl_i  (ctl_in),
        .cur_o  (cur)
    );

    wp_char_enc u_enc (
        .sym_i  (cur),
        .rd_i   (ln_q.rd),
        .code_o (enc_code),
        .rd_o   (enc_rd),
        .bad_o  (enc_bad)
    );

    always_comb begin
        ln_d      = ln_q;
        ln_d.code = enc_code;
        ln_d.rd   = enc_rd;
        ln_d.bad  = enc_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign code_out = ln_q.code;
    assign bad_ctl  = ln_q.bad;

    // R6
    code_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(ln_q.code) inside {4, 5, 6}));

    // R6
    rd_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ln_q.rd != $past(ln_q.rd)) == ($countones(ln_q.code) != 5)));

    // R5
    bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ln_q.bad |-> $past(cur.ctl));

endmodule

// File: tb/wordpair_8b10b_tx_tb_top.sv
module wordpair_8b10b_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 2;
    localparam int WDOG_LIMIT = 40000;

    localparam logic [5:0] SIX_TBL [0:31] = '{
        6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001, 6'b011001, 6'b111000,
        6'b111001, 6'b100101, 6'b010101, 6'b110100, 6'b001101, 6'b101100, 6'b011100, 6'b010111,
        6'b011011, 6'b100011, 6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
        6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110, 6'b011110, 6'b101011};
    localparam logic [3:0] DAT4_TBL [0:7] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100,
                                              4'b1101, 4'b1010, 4'b0110, 4'b1110};
    localparam logic [3:0] CTL4_TBL [0:7] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100,
                                              4'b1101, 4'b0101, 4'b1001, 4'b0111};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_n;
    logic [15:0] word_in;
    logic [1:0]  ctl_in;
    logic [9:0]  code_out;
    logic        bad_ctl;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    bit    idle_watch = 1'b0;
    string cur_req = "R3";

    // reference model state
    logic        m_sq, m_pv, m_rd, m_bad, m_lok, mk;
    logic [15:0] m_w, m_pw;
    logic [1:0]  m_k, m_pk;
    logic [7:0]  m_lo, mv;
    logic [9:0]  m_code;
    int          m_slot;

    // output-side trackers
    int         cdisp, run_len, ones;
    logic       last_bit, long_run;
    logic [9:0] prev_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    wordpair_8b10b_tx #(.LANES(LANES)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .word_in  (word_in),
        .ctl_in   (ctl_in),
        .code_out (code_out),
        .bad_ctl  (bad_ctl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void ref_enc(input logic [7:0] v, input logic k, input logic rd_in,
                                    output logic [9:0] c, output logic rd_out, output logic bad);
        int         x, y;
        logic       ok, kk, rd, alt;
        logic [5:0] s;
        logic [3:0] f;
        x   = int'(v[4:0]);
        y   = int'(v[7:5]);
        ok  = (x == 28) || (v == 8'hF7) || (v == 8'hFB) || (v == 8'hFD) || (v == 8'hFE);
        kk  = k && ok;
        bad = k && !ok;
        rd  = rd_in;
        s   = (kk && x == 28) ? 6'b001111 : SIX_TBL[x];
        if (rd && (($countones(s) != 3) || x == 7)) s = ~s;
        if ($countones(s) != 3) rd = ~rd;
        if (kk) begin
            f = CTL4_TBL[y];
            if (rd) f = ~f;
        end else begin
            alt = (y == 7) && ((!rd && (x == 17 || x == 18 || x == 20)) ||
                               ( rd && (x == 11 || x == 13 || x == 14)));
            f = alt ? 4'b0111 : DAT4_TBL[y];
            if (rd && (($countones(f) != 2) || y == 3)) f = ~f;
        end
        if ($countones(f) != 2) rd = ~rd;
        c      = {f[0], f[1], f[2], f[3], s[0], s[1], s[2], s[3], s[4], s[5]};
        rd_out = rd;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sq = 0; m_w = '0; m_k = '0; m_pv = 0; m_pw = '0; m_pk = '0;
            m_slot = 0; m_lo = '0; m_lok = 0; m_rd = 0; m_code = '0; m_bad = 0;
            live = 0;
        end else begin
            if (m_slot == 0) begin
                if (m_pv) begin
                    mv = m_pw[15:8]; mk = m_pk[1]; m_lo = m_pw[7:0]; m_lok = m_pk[0];
                end else begin
                    mv = 8'hBC; mk = 1'b1; m_lo = 8'h50; m_lok = 1'b0;
                end
            end else begin
                mv = m_lo; mk = m_lok;
            end
            ref_enc(mv, mk, m_rd, m_code, m_rd, m_bad);
            if (m_sq) begin
                m_pv = 1'b1; m_pw = m_w; m_pk = m_k;
            end else if (m_slot == 0) begin
                m_pv = 1'b0;
            end
            m_sq   = !wr_n;
            m_w    = word_in;
            m_k    = ctl_in;
            m_slot = (m_slot == LANES - 1) ? 0 : m_slot + 1;
            live   = 1;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (!rst_n || !live) begin
            run_len = 0; cdisp = -1; prev_code = '0; long_run = 0; last_bit = 0;
        end else if (!done) begin
            chk(cur_req, 32'(code_out), 32'(m_code));
            chk("R5", 32'(bad_ctl), 32'(m_bad));
            ones = $countones(code_out);
            chk("R6", 32'(ones >= 4 && ones <= 6), 32'd1);
            cdisp = cdisp + 2 * ones - 10;
            chk("R6", 32'(cdisp == -1 || cdisp == 1), 32'd1);
            for (int i = 0; i < 10; i++) begin
                if (run_len > 0 && code_out[i] == last_bit) begin
                    run_len++;
                end else begin
                    run_len = 1;
                    last_bit = code_out[i];
                end
                if (run_len > 5) long_run = 1;
            end
            chk("R6", 32'(long_run), 32'd0);
            long_run = 0;
            if (idle_watch) begin
                chk("R4", 32'((code_out == 10'h17C && (prev_code == 10'h289 || prev_code == 10'h000)) ||
                              (code_out == 10'h289 && prev_code == 10'h17C)), 32'd1);
            end
            prev_code = code_out;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic send(input logic [15:0] w, input logic [1:0] k, input int gap);
        @(negedge clk);
        wr_n = 1'b0; word_in = w; ctl_in = k;
        @(negedge clk);
        wr_n = 1'b1; word_in = 16'($urandom); ctl_in = 2'($urandom);
        repeat (gap - 1) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; wr_n = 1'b1; word_in = '0; ctl_in = '0;
        repeat (3) @(negedge clk);
        chk("R1", 32'(code_out), 32'd0);
        chk("R1", 32'(bad_ctl), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R7: first code is the negative-disparity comma, a on bit 0
        chk("R1", 32'(code_out), 32'h17C);
        chk("R7", 32'(code_out[5:0]), 32'h3C);

        // R2 R4: idle pair continues while inputs wander with wr_n high
        idle_watch = 1'b1;
        cur_req = "R2";
        for (int i = 0; i < 12; i++) begin
            word_in = 16'($urandom); ctl_in = 2'($urandom);
            @(negedge clk);
        end
        idle_watch = 1'b0;

        // R3: isolated words, varied phase against the slot
        cur_req = "R3";
        for (int i = 0; i < 10; i++) send(16'($urandom), 2'b00, 3 + (i % 3));
        send(16'h0102, 2'b00, 6);

        // R8: strobes every other clock, line stays full
        cur_req = "R8";
        for (int i = 0; i < 24; i++) send(16'($urandom), 2'b00, 1);
        repeat (6) @(negedge clk);

        // R8: strobes on adjacent clocks, later one may replace the waiting word
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            wr_n = 1'b0; word_in = 16'($urandom); ctl_in = 2'b00;
            @(negedge clk);
            word_in = 16'($urandom);
            @(negedge clk);
            wr_n = 1'b1;
            repeat (2 + (i % 2)) @(negedge clk);
        end

        // R9: every legal control byte on both lanes
        cur_req = "R9";
        for (int y = 0; y < 8; y++) begin
            logic [7:0] other;
            case (y % 4)
                0: other = 8'hF7;
                1: other = 8'hFB;
                2: other = 8'hFD;
                default: other = 8'hFE;
            endcase
            send({3'(y), 5'd28, other}, 2'b11, 1 + (y % 2));
            send({other, 3'(y), 5'd28}, 2'b11, 2);
        end

        // R5: illegal control requests, alone and beside legal ones
        cur_req = "R5";
        send(16'h00FF, 2'b11, 3);
        send(16'hBD3C, 2'b11, 2);
        send(16'h12BC, 2'b10, 4);
        send(16'hBCF6, 2'b01, 1);
        send(16'h7D7D, 2'b11, 3);

        // R10: random data and flags, random spacing, both disparity paths
        cur_req = "R10";
        for (int i = 0; i < 400; i++) begin
            logic [1:0] kk;
            kk = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            send(16'($urandom), kk, 1 + ($urandom % 3));
        end
        repeat (8) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule